// File: doc/BRIEF.md
# Flash Command Write Sequencer

This block watches the write traffic aimed at a flash module and turns a strict, ordered series of three writes into one command for a flash array controller. The first write goes into the array address space and captures a target address and a 32-bit data word. The second goes to a command register and names the operation: verify, program, page erase or mass erase. The third goes to a status register with its launch bit set. That launch write clears the buffer-empty flag and hands the command to the controller.

The captured address and data are shaped to suit the command before they are presented. A program keeps every address bit and the data word. A page erase drops the address bits inside the page and ignores the data. A mass erase or a verify presents neither address nor data. The sequencer also refuses to launch anything until a clock divider value has been written since reset, and it hands that divider value on to the controller.

Any write that breaks the order has the same effect: a step out of place, a stray write between steps, an unknown command code, a launch before the divider is set, or any write while a command is running. It sets a sticky access-error flag, abandons the partial sequence and empties the buffers. Software writes 1 to the clear bit of the status register to remove the flag. The controller signals completion with a done pulse, which sets a command-complete flag and makes the buffers available again.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, buf_empty is 1 and acc_err, cmd_complete, div_loaded and fc_req are all 0.
- R2: A write to register offset 0 while idle sets div_loaded and loads fc_div from wr_data[DIV_W-1:0]. div_loaded stays 0 until such a write happens.
- R3: The sequence is an array write, then a write to register offset 1 with the command code in wr_data[7:0], then a write to register offset 2 with wr_data bit 0 set. In the cycle after the launch write, fc_req is 1, buf_empty is 0 and fc_cmd holds the code.
- R4: Program (0x20) presents the full captured address on fc_addr and the captured word on fc_data.
- R5: Page erase (0x40) presents the captured address with bits [9:0] forced to 0, and presents fc_data as 0.
- R6: Mass erase (0x41) and verify (0x05) present fc_addr and fc_data as 0, whatever address and data were written.
- R7: fc_req stays 1 until fc_done is seen. In the cycle after fc_done, fc_req is 0, buf_empty is 1 and cmd_complete is 1. cmd_complete returns to 0 at the next successful launch.
- R8: A command code other than the four listed sets acc_err and returns the machine to idle with the buffers flushed, so a following launch write starts nothing.
- R9: A command write or a launch write while idle sets acc_err and raises no fc_req.
- R10: Any write between two steps breaks the sequence. A second array write, a divider write and a status write without the launch bit all count. Each one sets acc_err and returns the machine to idle, so a later launch starts nothing.
- R11: A launch write before any divider write sets acc_err and raises no fc_req.
- R12: acc_err is sticky through other writes. A status write with wr_data bit 1 set clears it, unless that same write raises a new error.
- R13: A write of any kind while a command runs sets acc_err. fc_req, fc_cmd, fc_addr and fc_data keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_array | input | 1 | 1 selects array space, 0 selects register space |
| wr_addr | input | ADDR_W | Array address, or register offset in bits [1:0] |
| wr_data | input | DATA_W | Write data |
| fc_done | input | 1 | Controller completion pulse |
| fc_req | output | 1 | Command presented to the controller |
| fc_cmd | output | 8 | Presented command code |
| fc_addr | output | ADDR_W | Presented address, shaped per command |
| fc_data | output | DATA_W | Presented data, zero unless program |
| fc_div | output | DIV_W | Stored timing divider |
| div_loaded | output | 1 | Divider written since reset |
| buf_empty | output | 1 | Buffers free for a new sequence |
| cmd_complete | output | 1 | Last launched command finished |
| acc_err | output | 1 | Sticky access error |

## Verification
All four command codes are run through the full sequence with addresses whose page-offset bits are nonzero and with data that is not zero. A masking mix-up, for example full address on a page erase or data leaking into an erase or verify, therefore shows on fc_addr or fc_data. The broken-order patterns come in four kinds: a step issued while idle, a stray write of each kind between steps, an unknown code, and a launch before the divider is set. Each is followed by a launch write, which tells a true flush apart from an error flag that leaves a half-built sequence alive. Writes issued during a running command confirm that the presented command is left untouched and only the error flag responds.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_VERIFY     = 8'h05;
    localparam logic [CMD_W-1:0] CMD_PROGRAM    = 8'h20;
    localparam logic [CMD_W-1:0] CMD_PAGE_ERASE = 8'h40;
    localparam logic [CMD_W-1:0] CMD_MASS_ERASE = 8'h41;

    localparam logic [1:0] OFS_DIV  = 2'd0;
    localparam logic [1:0] OFS_CMD  = 2'd1;
    localparam logic [1:0] OFS_STAT = 2'd2;

    localparam int STAT_LAUNCH_BIT = 0;
    localparam int STAT_CLR_BIT    = 1;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_ARRAY,
        EV_DIV,
        EV_CMD,
        EV_LAUNCH,
        EV_STAT,
        EV_OTHER
    } bus_ev_e;

    typedef struct packed {
        bus_ev_e ev;
        logic    clr_err;
    } bus_evt_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HAVE_DATA,
        ST_HAVE_CMD,
        ST_BUSY
    } seq_state_e;

    typedef struct packed {
        logic load_data;
        logic load_cmd;
        logic flush;
        logic div_we;
    } seq_ctl_t;

    function automatic logic cmd_known(input logic [CMD_W-1:0] c);
        return (c == CMD_VERIFY) || (c == CMD_PROGRAM) ||
               (c == CMD_PAGE_ERASE) || (c == CMD_MASS_ERASE);
    endfunction

    function automatic logic cmd_uses_data(input logic [CMD_W-1:0] c);
        return c == CMD_PROGRAM;
    endfunction

    function automatic logic cmd_uses_addr(input logic [CMD_W-1:0] c);
        return (c == CMD_PROGRAM) || (c == CMD_PAGE_ERASE);
    endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  logic              wr_array,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output bus_evt_t          evt
);

    always_comb begin
        evt.ev      = EV_NONE;
        evt.clr_err = 1'b0;
        if (wr_en) begin
            if (wr_array) begin
                evt.ev = EV_ARRAY;
            end else begin
                unique case (wr_addr[1:0])
                    OFS_DIV:  evt.ev = EV_DIV;
                    OFS_CMD:  evt.ev = EV_CMD;
                    OFS_STAT: begin
                        evt.ev      = wr_data[STAT_LAUNCH_BIT] ? EV_LAUNCH : EV_STAT;
                        evt.clr_err = wr_data[STAT_CLR_BIT];
                    end
                    default:  evt.ev = EV_OTHER;
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_div_reg.sv
module flash_div_reg #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [DIV_W-1:0] din,
    output logic [DIV_W-1:0] div_q,
    output logic             loaded
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            loaded <= 1'b0;
        end else if (we) begin
            div_q  <= din;
            loaded <= 1'b1;
        end
    end

    // R2
    div_load_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (loaded && div_q == $past(din)));

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  logic     cmd_ok,
    input  logic     div_loaded,
    input  logic     fc_done,
    output seq_ctl_t ctl,
    output logic     busy,
    output logic     acc_err,
    output logic     complete
);

    seq_state_e state, state_d;
    logic       err_set;
    logic       cmpl_set;
    logic       cmpl_clr;

    always_comb begin
        state_d  = state;
        ctl      = '0;
        err_set  = 1'b0;
        cmpl_set = 1'b0;
        cmpl_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                unique case (evt.ev)
                    EV_ARRAY: begin
                        ctl.load_data = 1'b1;
                        state_d       = ST_HAVE_DATA;
                    end
                    EV_DIV:              ctl.div_we = 1'b1;
                    EV_CMD, EV_LAUNCH:   err_set    = 1'b1;
                    default: ;
                endcase
            end
            ST_HAVE_DATA: begin
                if (evt.ev == EV_CMD && cmd_ok) begin
                    ctl.load_cmd = 1'b1;
                    state_d      = ST_HAVE_CMD;
                end else if (evt.ev != EV_NONE) begin
                    err_set   = 1'b1;
                    ctl.flush = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_HAVE_CMD: begin
                if (evt.ev == EV_LAUNCH && div_loaded) begin
                    cmpl_clr = 1'b1;
                    state_d  = ST_BUSY;
                end else if (evt.ev != EV_NONE) begin
                    err_set   = 1'b1;
                    ctl.flush = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (evt.ev != EV_NONE) err_set = 1'b1;
                if (fc_done) begin
                    cmpl_set  = 1'b1;
                    ctl.flush = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            acc_err  <= 1'b0;
            complete <= 1'b0;
        end else begin
            state <= state_d;
            if (err_set)          acc_err <= 1'b1;
            else if (evt.clr_err) acc_err <= 1'b0;
            if (cmpl_set)         complete <= 1'b1;
            else if (cmpl_clr)    complete <= 1'b0;
        end
    end

    assign busy = (state == ST_BUSY);

    // R11
    busy_needs_div_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> div_loaded);

    // R3
    busy_from_launch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(evt.ev == EV_LAUNCH));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fc_done) |=> busy);

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_err && !evt.clr_err) |=> acc_err);

endmodule

// File: rtl/flash_cmd_buffer.sv
module flash_cmd_buffer
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_data,
    input  logic              load_cmd,
    input  logic              flush,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CMD_W-1:0]  cmd_in,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [ADDR_W-1:0] addr_eff,
    output logic [DATA_W-1:0] data_eff
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            addr_q <= '0;
            data_q <= '0;
            cmd_q  <= '0;
        end else begin
            if (load_data) begin
                addr_q <= addr_in;
                data_q <= data_in;
            end
            if (load_cmd) cmd_q <= cmd_in;
        end
    end

    always_comb begin
        addr_eff = '0;
        if (cmd_uses_addr(cmd_q)) begin
            addr_eff = (cmd_q == CMD_PAGE_ERASE) ? (addr_q & PAGE_MASK) : addr_q;
        end
        data_eff = cmd_uses_data(cmd_q) ? data_q : '0;
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 32,
    parameter int DIV_W     = 7,
    parameter int PAGE_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_array,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fc_done,
    output logic              fc_req,
    output logic [7:0]        fc_cmd,
    output logic [ADDR_W-1:0] fc_addr,
    output logic [DATA_W-1:0] fc_data,
    output logic [DIV_W-1:0]  fc_div,
    output logic              div_loaded,
    output logic              buf_empty,
    output logic              cmd_complete,
    output logic              acc_err
);

    bus_evt_t          evt;
    seq_ctl_t          ctl;
    logic              busy;
    logic              cmd_ok;
    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] addr_eff;
    logic [DATA_W-1:0] data_eff;

    assign cmd_ok = cmd_known(wr_data[CMD_W-1:0]);

    flash_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .wr_en    (wr_en),
        .wr_array (wr_array),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .evt      (evt)
    );

    flash_div_reg #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .we     (ctl.div_we),
        .din    (wr_data[DIV_W-1:0]),
        .div_q  (fc_div),
        .loaded (div_loaded)
    );

    flash_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .cmd_ok     (cmd_ok),
        .div_loaded (div_loaded),
        .fc_done    (fc_done),
        .ctl        (ctl),
        .busy       (busy),
        .acc_err    (acc_err),
        .complete   (cmd_complete)
    );

    flash_cmd_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load_data (ctl.load_data),
        .load_cmd  (ctl.load_cmd),
        .flush     (ctl.flush),
        .addr_in   (wr_addr),
        .data_in   (wr_data),
        .cmd_in    (wr_data[CMD_W-1:0]),
        .cmd_q     (cmd_q),
        .addr_eff  (addr_eff),
        .data_eff  (data_eff)
    );

    assign fc_req    = busy;
    assign buf_empty = !busy;
    assign fc_cmd    = busy ? cmd_q : '0;
    assign fc_addr   = busy ? addr_eff : '0;
    assign fc_data   = busy ? data_eff : '0;

    // R5
    page_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (fc_req && fc_cmd == CMD_PAGE_ERASE) |-> (fc_addr[PAGE_BITS-1:0] == '0 && fc_data == '0));

    // R13
    cmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (fc_req && $past(fc_req)) |-> ($stable(fc_cmd) && $stable(fc_addr) && $stable(fc_data)));

    // R6
    no_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (fc_req && (fc_cmd == CMD_MASS_ERASE || fc_cmd == CMD_VERIFY)) |-> (fc_addr == '0));

endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 7;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic              wr_array;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              fc_done;
    logic              fc_req;
    logic [7:0]        fc_cmd;
    logic [ADDR_W-1:0] fc_addr;
    logic [DATA_W-1:0] fc_data;
    logic [DIV_W-1:0]  fc_div;
    logic              div_loaded;
    logic              buf_empty;
    logic              cmd_complete;
    logic              acc_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    flash_cmd_seq dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_array(wr_array),
        .wr_addr(wr_addr), .wr_data(wr_data), .fc_done(fc_done),
        .fc_req(fc_req), .fc_cmd(fc_cmd), .fc_addr(fc_addr), .fc_data(fc_data),
        .fc_div(fc_div), .div_loaded(div_loaded), .buf_empty(buf_empty),
        .cmd_complete(cmd_complete), .acc_err(acc_err)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic arr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_array = arr; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_array = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic reg_wr(input logic [1:0] ofs, input logic [DATA_W-1:0] d);
        bus_wr(1'b0, ADDR_W'(ofs), d);
    endtask

    task automatic full_seq(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic [7:0] c);
        bus_wr(1'b1, a, d);
        reg_wr(2'd1, DATA_W'(c));
        reg_wr(2'd2, 32'h1);
    endtask

    task automatic clr_err();
        reg_wr(2'd2, 32'h2);
    endtask

    task automatic finish_cmd(input string tag);
        repeat (3) @(negedge clk);
        check({tag, " R7 req held"}, fc_req, 1);
        fc_done = 1'b1;
        @(negedge clk);
        fc_done = 1'b0;
        check({tag, " R7 req drop"}, fc_req, 0);
        check({tag, " R7 buf_empty"}, buf_empty, 1);
        check({tag, " R7 complete"}, cmd_complete, 1);
    endtask

    task automatic t_reset();
        check("R1 buf_empty", buf_empty, 1);
        check("R1 acc_err", acc_err, 0);
        check("R1 complete", cmd_complete, 0);
        check("R1 div_loaded", div_loaded, 0);
        check("R1 fc_req", fc_req, 0);
    endtask

    task automatic t_no_div();
        full_seq(20'h00100, 32'h1, 8'h20);
        check("R11 acc_err", acc_err, 1);
        check("R11 fc_req", fc_req, 0);
        check("R11 div_loaded", div_loaded, 0);
    endtask

    task automatic t_clear();
        reg_wr(2'd0, 32'h0);
        check("R12 sticky", acc_err, 1);
        check("R2 loaded", div_loaded, 1);
        check("R2 value", fc_div, 7'h00);
        reg_wr(2'd0, 32'h154);
        check("R2 value2", fc_div, 7'h54);
        clr_err();
        check("R12 cleared", acc_err, 0);
    endtask

    task automatic t_program();
        full_seq(20'hA5C37, 32'hDEADBEEF, 8'h20);
        check("R3 req", fc_req, 1);
        check("R3 buf_empty", buf_empty, 0);
        check("R3 cmd", fc_cmd, 8'h20);
        check("R4 addr", fc_addr, 20'hA5C37);
        check("R4 data", fc_data, 32'hDEADBEEF);
        finish_cmd("prog");
    endtask

    task automatic t_page();
        full_seq(20'h12FFF, 32'h12345678, 8'h40);
        check("R7 complete cleared", cmd_complete, 0);
        check("R5 cmd", fc_cmd, 8'h40);
        check("R5 addr", fc_addr, 20'h12C00);
        check("R5 data", fc_data, 0);
        finish_cmd("page");
    endtask

    task automatic t_mass_verify();
        full_seq(20'h55555, 32'hFFFF0000, 8'h41);
        check("R6 mass cmd", fc_cmd, 8'h41);
        check("R6 mass addr", fc_addr, 0);
        check("R6 mass data", fc_data, 0);
        finish_cmd("mass");
        full_seq(20'h00ABC, 32'hCAFE0001, 8'h05);
        check("R6 verify cmd", fc_cmd, 8'h05);
        check("R6 verify addr", fc_addr, 0);
        check("R6 verify data", fc_data, 0);
        finish_cmd("verify");
        check("R6 no error", acc_err, 0);
    endtask

    task automatic t_bad_cmd();
        bus_wr(1'b1, 20'h00400, 32'h11);
        reg_wr(2'd1, 32'h33);
        check("R8 acc_err", acc_err, 1);
        clr_err();
        check("R8 cleared", acc_err, 0);
        reg_wr(2'd2, 32'h1);
        check("R8 flushed launch err", acc_err, 1);
        check("R8 no req", fc_req, 0);
        clr_err();
    endtask

    task automatic t_out_of_order();
        reg_wr(2'd1, 32'h20);
        check("R9 cmd idle err", acc_err, 1);
        check("R9 cmd idle req", fc_req, 0);
        clr_err();
        reg_wr(2'd2, 32'h1);
        check("R9 launch idle err", acc_err, 1);
        check("R9 launch idle req", fc_req, 0);
        clr_err();
    endtask

    task automatic t_intermediate();
        bus_wr(1'b1, 20'h00800, 32'h5);
        bus_wr(1'b1, 20'h00804, 32'h6);
        check("R10 double array err", acc_err, 1);
        clr_err();
        reg_wr(2'd1, 32'h20);
        check("R10 flushed cmd err", acc_err, 1);
        clr_err();
        bus_wr(1'b1, 20'h00800, 32'h5);
        reg_wr(2'd1, 32'h20);
        reg_wr(2'd0, 32'h10);
        check("R10 div mid err", acc_err, 1);
        check("R10 div unchanged", fc_div, 7'h54);
        clr_err();
        reg_wr(2'd2, 32'h1);
        check("R10 launch after abort", fc_req, 0);
        clr_err();
        bus_wr(1'b1, 20'h00800, 32'h5);
        reg_wr(2'd1, 32'h20);
        reg_wr(2'd2, 32'h0);
        check("R10 stat mid err", acc_err, 1);
        reg_wr(2'd2, 32'h3);
        check("R10 stat then launch req", fc_req, 0);
        check("R12 err raised wins", acc_err, 1);
        clr_err();
        check("R12 clear again", acc_err, 0);
    endtask

    task automatic t_busy_write();
        full_seq(20'h3F001, 32'h0BADF00D, 8'h20);
        check("R13 start", fc_req, 1);
        bus_wr(1'b1, 20'h11111, 32'h22222222);
        check("R13 err", acc_err, 1);
        check("R13 req", fc_req, 1);
        check("R13 addr", fc_addr, 20'h3F001);
        check("R13 data", fc_data, 32'h0BADF00D);
        reg_wr(2'd1, 32'h41);
        check("R13 cmd", fc_cmd, 8'h20);
        finish_cmd("busy");
        clr_err();
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_array = 1'b0; wr_addr = '0; wr_data = '0; fc_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_div();
        t_clear();
        t_program();
        t_page();
        t_mass_verify();
        t_bad_cmd();
        t_out_of_order();
        t_intermediate();
        t_busy_write();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule